// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. A lookup gives a virtual address, the current address-space tag and a read/write flag. Every stored entry is compared at once. One cycle later the block returns one of three results: a hit with the physical address, a miss, or a protection fault. The physical address is the stored frame number with the untouched page offset placed below it.

On a miss the block only reports the miss. An outside walker fetches the translation and writes it back through the refill port. A refill first takes a free slot. When no slot is free, a rotating pointer picks the victim and steps over locked entries. A separate control locks or unlocks the entry that matches a given page and tag, and locked entries survive both eviction and flushing. There are two flush controls. One clears every unlocked entry. The other clears only the unlocked entries of one address space, so switching between processes needs no flush at all.

Top module: `tlb_asid_top`

## Requirements
- R1: A lookup presented in one cycle produces its response exactly one cycle later: `rsp_valid` is high for that one cycle, and on a hit `rsp_paddr` equals the stored frame concatenated above the lookup's low `OFF_W` offset bits.
- R2: A hit needs a valid entry whose page number and address-space tag both equal the lookup's. A lookup with the same page but another tag misses (`rsp_miss`=1, `rsp_hit`=0, `rsp_paddr`=0).
- R3: A write (`lk_write`=1) that hits an entry refilled with `fill_writable`=0 gives `rsp_fault`=1 and `rsp_paddr`=0. A read of that entry translates normally. Reads and writes of writable entries never fault.
- R4: A refill whose page and tag already match a valid entry overwrites that entry in place. Otherwise it takes the lowest-numbered invalid entry.
- R5: With every entry valid, a refill replaces the first unlocked entry found by scanning upward from the rotating pointer, wrapping past the top. The pointer then moves to the entry after the victim. The pointer is 0 after reset.
- R6: `pin_valid` with `pin_set`=1 locks the valid entry that matches `pin_vpn`/`pin_asid`, and `pin_set`=0 unlocks it. A locked entry is never chosen as a refill victim.
- R7: `flush_all` invalidates every unlocked entry. Locked entries still hit afterwards.
- R8: `flush_asid_en` invalidates only the unlocked entries whose tag equals `flush_asid`. Entries of other tags still hit.
- R9: A refill that finds every entry locked changes no entry and sets `fill_drop`. The flag stays set until a later refill is accepted.
- R10: After reset, all entries are invalid, `rsp_valid`, `rsp_hit`, `rsp_fault` and `fill_drop` are 0, and any lookup misses. Within one cycle, control actions are taken in this order of priority: full flush, tag flush, refill, lock control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address: page number above, offset below |
| lk_asid | input | ASID_W | Address-space tag of the lookup |
| lk_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | A matching entry was found |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Write to a read-only entry |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, 0 unless translated |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Tag to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_writable | input | 1 | 1 = writes allowed |
| fill_drop | output | 1 | Last refill was refused because every entry was locked |
| pin_valid | input | 1 | Lock-control request |
| pin_set | input | 1 | 1 = lock, 0 = unlock |
| pin_vpn | input | VPN_W | Page number of the entry to lock or unlock |
| pin_asid | input | ASID_W | Tag of the entry to lock or unlock |
| flush_all | input | 1 | Invalidate every unlocked entry |
| flush_asid_en | input | 1 | Invalidate the unlocked entries of one tag |
| flush_asid | input | ASID_W | Tag for the selective flush |

## Verification
Some faults in the stored state show up at once. A corrupted tag, frame or permission bit changes the response of the very next lookup that touches that entry, one cycle after the request. Other faults stay hidden until a later refill or flush. A wrong victim choice or a drifted rotating pointer shows up only there, as a lost translation (a miss where a hit was due) or a surviving stale one. The bench therefore fills the array to capacity in a known order. After each eviction, flush and lock change, it probes every page that was affected, so a wrong slot or a wrong pointer position is seen within a few cycles.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_FLUSH_ALL,
    OP_FLUSH_ASID,
    OP_FILL,
    OP_PIN
  } tlb_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]      valid,
  input  logic [VPN_W-1:0]  tag_vpn  [N],
  input  logic [ASID_W-1:0] tag_asid [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic [N-1:0]      match,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tag_vpn[g] == key_vpn) && (tag_asid[g] == key_asid);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     pinned,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic [IDX_W-1:0] victim,
  output logic             use_rr,
  output logic             none_free
);
  logic             free_found, rr_found;
  logic [IDX_W-1:0] free_idx, rr_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!free_found && !valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    rr_found = 1'b0;
    rr_idx   = '0;
    for (int k = 0; k < N; k++) begin
      int s;
      s = int'(rr_ptr) + k;
      if (s >= N) s = s - N;
      if (!rr_found && !pinned[s]) begin
        rr_found = 1'b1;
        rr_idx   = IDX_W'(s);
      end
    end
  end

  assign victim    = free_found ? free_idx : rr_idx;
  assign use_rr    = !free_found && rr_found;
  assign none_free = !free_found && !rr_found;

  // R6: a chosen victim is never a locked entry
  assert_victim_unpinned_R6: assert property (@(posedge clk) disable iff (rst)
    !none_free |-> !pinned[victim]);
  // R4: a free slot is always preferred over eviction
  assert_free_first_R4: assert property (@(posedge clk) disable iff (rst)
    (valid != {N{1'b1}}) |-> !valid[victim]);
endmodule

// File: rtl/tlb_asid_top.sv
module tlb_asid_top
  import tlb_asid_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int VPN_W     = 20,
  parameter int PFN_W     = 20,
  parameter int ASID_W    = 8,
  parameter int OFF_W     = 12,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int VA_W     = VPN_W + OFF_W,
  localparam int PA_W     = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_writable,
  output logic              fill_drop,
  input  logic              pin_valid,
  input  logic              pin_set,
  input  logic [VPN_W-1:0]  pin_vpn,
  input  logic [ASID_W-1:0] pin_asid,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  localparam int N = N_ENTRIES;

  // entry state
  logic [N-1:0]      valid_q, pin_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [N-1:0]      wr_q;
  logic [IDX_W-1:0]  rr_q;

  // lookup side
  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  logic [N-1:0]     lk_match;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic             lk_ro;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q),
    .key_vpn(lk_vpn), .key_asid(lk_asid),
    .match(lk_match), .hit(lk_hit), .hit_idx(lk_idx)
  );

  // control side key: refill has priority over lock control
  logic [VPN_W-1:0]  ctl_vpn;
  logic [ASID_W-1:0] ctl_asid;
  logic [N-1:0]      ctl_match;
  logic              ctl_hit;
  logic [IDX_W-1:0]  ctl_idx;

  assign ctl_vpn  = fill_valid ? fill_vpn  : pin_vpn;
  assign ctl_asid = fill_valid ? fill_asid : pin_asid;

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_ctl_match (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q),
    .key_vpn(ctl_vpn), .key_asid(ctl_asid),
    .match(ctl_match), .hit(ctl_hit), .hit_idx(ctl_idx)
  );

  logic [IDX_W-1:0] victim;
  logic             use_rr, none_free;

  tlb_victim #(.N(N)) u_victim (
    .clk(clk), .rst(rst),
    .valid(valid_q), .pinned(pin_q), .rr_ptr(rr_q),
    .victim(victim), .use_rr(use_rr), .none_free(none_free)
  );

  // operation decode
  tlb_op_e op;
  always_comb begin
    if (flush_all)          op = OP_FLUSH_ALL;
    else if (flush_asid_en) op = OP_FLUSH_ASID;
    else if (fill_valid)    op = OP_FILL;
    else if (pin_valid)     op = OP_PIN;
    else                    op = OP_IDLE;
  end

  logic             fill_ok;
  logic [IDX_W-1:0] fill_idx;
  assign fill_ok  = (op == OP_FILL) && (ctl_hit || !none_free);
  assign fill_idx = ctl_hit ? ctl_idx : victim;

  // entry payload: written only on an accepted refill, no reset needed
  always_ff @(posedge clk) begin
    if (fill_ok) begin
      vpn_q[fill_idx]  <= fill_vpn;
      asid_q[fill_idx] <= fill_asid;
      pfn_q[fill_idx]  <= fill_pfn;
      wr_q[fill_idx]   <= fill_writable;
    end
  end

  // entry status, rotating pointer, drop flag
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      pin_q     <= '0;
      rr_q      <= '0;
      fill_drop <= 1'b0;
    end else begin
      unique case (op)
        OP_FLUSH_ALL:  valid_q <= valid_q & pin_q;
        OP_FLUSH_ASID: begin
          for (int i = 0; i < N; i++) begin
            if (!pin_q[i] && asid_q[i] == flush_asid) valid_q[i] <= 1'b0;
          end
        end
        OP_FILL: begin
          if (fill_ok) begin
            valid_q[fill_idx] <= 1'b1;
            fill_drop         <= 1'b0;
            if (!ctl_hit && use_rr) begin
              rr_q <= (int'(victim) == N - 1) ? '0 : victim + 1'b1;
            end
          end else begin
            fill_drop <= 1'b1;
          end
        end
        OP_PIN: begin
          if (ctl_hit) pin_q[ctl_idx] <= pin_set;
        end
        default: ;
      endcase
    end
  end

  // registered lookup response
  assign lk_ro = !wr_q[lk_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit;
      rsp_miss  <= lk_valid && !lk_hit;
      rsp_fault <= lk_valid && lk_hit && lk_write && lk_ro;
      if (lk_valid && lk_hit && !(lk_write && lk_ro)) rsp_paddr <= {pfn_q[lk_idx], lk_off};
      else                                            rsp_paddr <= '0;
    end
  end

  // R1: one response per request, one cycle later
  assert_rsp_timing_R1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  // R2: a response is exactly one of hit or miss
  assert_hit_or_miss_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss}) == 1));
  // R3: a fault only on a hit, and it carries no address
  assert_fault_hit_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_hit && rsp_paddr == '0));
  // R4: in-place overwrite keeps every key unique
  assert_unique_match_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(lk_match) <= 1);
  // R6: a locked entry stays valid
  assert_pinned_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (pin_q & ~valid_q) == '0);
  // R9: the drop flag rises only when every entry was locked
  assert_drop_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fill_drop) |-> ($past(pin_q) == {N{1'b1}}));
endmodule

// File: tb/tlb_asid_top_tb.sv
`timescale 1ns/1ps
module tlb_asid_top_tb;
  localparam int N = 4, VW = 6, PW = 6, AW = 2, OW = 4;

  logic clk = 0, rst = 1;
  logic lk_valid = 0, lk_write = 0;
  logic [VW+OW-1:0] lk_vaddr = '0;
  logic [AW-1:0] lk_asid = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, fill_drop;
  logic [PW+OW-1:0] rsp_paddr;
  logic fill_valid = 0, fill_writable = 0;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic pin_valid = 0, pin_set = 0;
  logic [VW-1:0] pin_vpn = '0;
  logic [AW-1:0] pin_asid = '0;
  logic flush_all = 0, flush_asid_en = 0;
  logic [AW-1:0] flush_asid = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tlb_asid_top #(.N_ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW), .OFF_W(OW)) u_dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_writable(fill_writable), .fill_drop(fill_drop),
    .pin_valid(pin_valid), .pin_set(pin_set), .pin_vpn(pin_vpn), .pin_asid(pin_asid),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
  );

  function automatic logic [PW-1:0] frame_of(input logic [VW-1:0] v);
    return v ^ 6'h2A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [VW-1:0] v, input logic [AW-1:0] a, input logic [OW-1:0] off,
                        input bit wr, input bit e_hit, input bit e_fault,
                        input logic [PW-1:0] e_pfn, input string req);
    logic [PW+OW-1:0] e_pa;
    @(negedge clk);
    lk_valid = 1; lk_vaddr = {v, off}; lk_asid = a; lk_write = wr;
    @(negedge clk);
    lk_valid = 0; lk_write = 0;
    e_pa = (e_hit && !e_fault) ? {e_pfn, off} : '0;
    check(rsp_valid && rsp_hit == e_hit && rsp_miss == !e_hit && rsp_fault == e_fault
          && rsp_paddr == e_pa, req,
          {rsp_valid, rsp_hit, rsp_miss, rsp_fault, 2'b0, rsp_paddr},
          {1'b1, e_hit, !e_hit, e_fault, 2'b0, e_pa});
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [AW-1:0] a,
                      input logic [PW-1:0] p, input bit w);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_writable = w;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic pin(input logic [VW-1:0] v, input logic [AW-1:0] a, input bit s);
    @(negedge clk);
    pin_valid = 1; pin_vpn = v; pin_asid = a; pin_set = s;
    @(negedge clk);
    pin_valid = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    check(!rsp_valid && !rsp_hit && !rsp_fault && !fill_drop, "R10",
          {rsp_valid, rsp_hit, rsp_fault, fill_drop}, 0);
    lookup(6'd1, 0, 4'h3, 0, 0, 0, 0, "R10 empty lookup");

    // R4: fills land in slots 0..3; odd pages read-only
    for (int v = 1; v <= 4; v++) fill(6'(v), 0, frame_of(6'(v)), v % 2 == 0);

    // R1: full offset sweep on every page
    for (int v = 1; v <= 4; v++)
      for (int o = 0; o < 16; o++)
        lookup(6'(v), 0, 4'(o), 0, 1, 0, frame_of(6'(v)), "R1 read sweep");

    // R2: other tags never match
    for (int v = 1; v <= 4; v++)
      for (int a = 1; a < 4; a++)
        lookup(6'(v), 2'(a), 4'h5, 0, 0, 0, 0, "R2 tag mismatch");
    lookup(6'd0, 0, 4'h1, 0, 0, 0, 0, "R2 unmapped page");

    // R3: protection
    lookup(6'd1, 0, 4'h7, 1, 1, 1, 0, "R3 write read-only");
    lookup(6'd3, 0, 4'h2, 1, 1, 1, 0, "R3 write read-only");
    lookup(6'd2, 0, 4'h9, 1, 1, 0, frame_of(6'd2), "R3 write writable");
    lookup(6'd4, 0, 4'hA, 1, 1, 0, frame_of(6'd4), "R3 write writable");

    // R5: full, pointer 0 -> slot 0 (page 1) evicted
    fill(6'd5, 0, frame_of(6'd5), 1);
    lookup(6'd1, 0, 4'h0, 0, 0, 0, 0, "R5 evict slot0");
    lookup(6'd5, 0, 4'h1, 0, 1, 0, frame_of(6'd5), "R5 new entry");

    // R6: lock page 2 (slot 1); pointer at 1 skips it -> slot 2 (page 3)
    pin(6'd2, 0, 1);
    fill(6'd6, 0, frame_of(6'd6), 0);
    lookup(6'd2, 0, 4'h2, 0, 1, 0, frame_of(6'd2), "R6 locked kept");
    lookup(6'd3, 0, 4'h2, 0, 0, 0, 0, "R5 skip to slot2");
    lookup(6'd6, 0, 4'h4, 0, 1, 0, frame_of(6'd6), "R5 new entry slot2");

    // R5: pointer at 3 -> slot 3 (page 4) replaced with a tag-1 page
    fill(6'd7, 1, frame_of(6'd7), 1);
    lookup(6'd4, 0, 4'h3, 0, 0, 0, 0, "R5 evict slot3");
    lookup(6'd7, 1, 4'h3, 0, 1, 0, frame_of(6'd7), "R5 tag1 entry");

    // R8: tag flush
    @(negedge clk); flush_asid_en = 1; flush_asid = 1;
    @(negedge clk); flush_asid_en = 0;
    lookup(6'd7, 1, 4'h3, 0, 0, 0, 0, "R8 flushed tag");
    lookup(6'd5, 0, 4'h3, 0, 1, 0, frame_of(6'd5), "R8 other tag kept");

    // R7: full flush keeps locked page 2
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
    lookup(6'd5, 0, 4'h1, 0, 0, 0, 0, "R7 flushed");
    lookup(6'd6, 0, 4'h1, 0, 0, 0, 0, "R7 flushed");
    lookup(6'd2, 0, 4'h1, 0, 1, 0, frame_of(6'd2), "R7 locked survives");

    // R9: lock all, refill refused
    fill(6'd8, 0, frame_of(6'd8), 1);
    fill(6'd9, 0, frame_of(6'd9), 1);
    fill(6'd10, 0, frame_of(6'd10), 1);
    pin(6'd8, 0, 1); pin(6'd9, 0, 1); pin(6'd10, 0, 1);
    fill(6'd11, 0, frame_of(6'd11), 1);
    check(fill_drop == 1, "R9 drop flag", fill_drop, 1);
    lookup(6'd11, 0, 4'h0, 0, 0, 0, 0, "R9 not installed");
    lookup(6'd8, 0, 4'h0, 0, 1, 0, frame_of(6'd8), "R9 entries unchanged");
    check(fill_drop == 1, "R9 flag held", fill_drop, 1);

    // R6: unlock page 8 (slot 0); pointer 0 -> slot 0
    pin(6'd8, 0, 0);
    fill(6'd11, 0, frame_of(6'd11), 1);
    check(fill_drop == 0, "R9 flag cleared", fill_drop, 0);
    lookup(6'd11, 0, 4'h6, 0, 1, 0, frame_of(6'd11), "R6 unlocked evictable");
    lookup(6'd8, 0, 4'h6, 0, 0, 0, 0, "R6 unlocked evicted");

    // R4: refill of an existing key overwrites in place
    fill(6'd2, 0, 6'h15, 1);
    lookup(6'd2, 0, 4'hE, 0, 1, 0, 6'h15, "R4 overwrite");
    lookup(6'd9, 0, 4'hE, 0, 1, 0, frame_of(6'd9), "R4 others intact");
    lookup(6'd11, 0, 4'hE, 0, 1, 0, frame_of(6'd11), "R4 others intact");

    summary();
  end
endmodule